// File: doc/BRIEF.md
# DMA Transfer Count Register

This block holds the transfer count for one DMA channel. A CPU reads and writes it as a 32-bit register through a 16-bit word port, one half at a time. The DMA engine pulses a completion input after each transfer, and the block then counts that transfer down.

A mode pin selects between two layouts. In normal layout, bits 23:0 are one counter. In block layout, bits 23:16 hold a block size that transfers never change, and bits 15:0 are the counter. An active counter that already reads zero means transfers are not counted.

When a transfer takes the active counter from 1 to 0, the block raises a one-cycle end pulse. A CPU write in the same cycle as a transfer always decides the stored value, but it does not cancel an end that the transfer caused. For a longword read, the upper-word access takes a snapshot, and the lower-word access that follows returns the buffered half. The two halves therefore agree while transfers continue. No data stream passes through this block, so every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `dma_tcount_unit`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0, the end pulse is low and the longword snapshot buffer holds 0.
- R2: In normal layout (mode_blk=0), each xfer_done pulse with a nonzero count decrements bits 23:0 by exactly 1, and the borrow may cross bit 16.
- R3: In block layout (mode_blk=1), xfer_done decrements only bits 15:0. Bits 23:16 keep their value.
- R4: When the active counter is 0 (bits 23:0 in normal layout, bits 15:0 in block layout), xfer_done leaves the whole register unchanged and gives no end pulse.
- R5: xfer_end is high for exactly the one cycle after the clock edge at which an xfer_done pulse finds the active counter equal to 1.
- R6: When cpu_wr and xfer_done occur in the same cycle, there is no decrement. The selected half takes the written data and the other half keeps its old value.
- R7: When a CPU write coincides with a transfer that finds the active counter equal to 1, the written value is stored and xfer_end still pulses.
- R8: A CPU write of 0 with no coinciding transfer does not raise xfer_end.
- R9: Bits 31:24 always read 0. An upper-half write (cpu_wr_hi=1) stores only cpu_wdata[7:0] into bits 23:16.
- R10: A lower-half write (cpu_wr_hi=0) sets bits 15:0 and leaves bits 23:16 unchanged. An upper-half write leaves bits 15:0 unchanged.
- R11: A read with cpu_rd_long=1 and cpu_rd_hi=1 returns the live bits 31:16 and captures the live bits 15:0. A later read with cpu_rd_long=1 and cpu_rd_hi=0 returns the captured bits, while a read with cpu_rd_long=0 returns live bits. cpu_rdata is combinational and is 0 when cpu_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_blk | input | 1 | 0 = normal layout, 1 = block layout |
| cpu_wr | input | 1 | CPU word write strobe |
| cpu_wr_hi | input | 1 | Write half select: 1 = bits 31:16, 0 = bits 15:0 |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rd | input | 1 | CPU word read strobe |
| cpu_rd_hi | input | 1 | Read half select: 1 = bits 31:16, 0 = bits 15:0 |
| cpu_rd_long | input | 1 | Marks the read as one half of a longword access |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| xfer_done | input | 1 | One pulse per completed DMA transfer |
| count_o | output | 32 | Live register value |
| xfer_end | output | 1 | One-cycle pulse on terminal count |

## Verification
The bench builds the block with its default widths: a 32-bit register, a 16-bit bus, a 24-bit normal counter and a 16-bit block counter. With these widths a borrow across the word boundary (0x010000 to 0x00FFFF) takes a single transfer, and a snapshot taken at 0x120000 shows the difference between the coherent and the live halves after one decrement. A block size of 0x5A sits above a counter that is driven to zero and held there. Collisions of a CPU write with a transfer are tested for both halves and at the 1-to-0 edge.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int REG_W_DEF     = 32;
  localparam int BUS_W_DEF     = 16;
  localparam int CNT_W_DEF     = 24;
  localparam int BLK_CNT_W_DEF = 16;

  typedef enum logic {
    LAYOUT_NORMAL = 1'b0,
    LAYOUT_BLOCK  = 1'b1
  } layout_e;
endpackage

// File: rtl/dtc_count_core.sv
module dtc_count_core
  import dtc_pkg::*;
#(
  parameter int CNT_W     = CNT_W_DEF,
  parameter int BUS_W     = BUS_W_DEF,
  parameter int BLK_CNT_W = BLK_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  layout_e          layout,
  input  logic             cpu_wr,
  input  logic             cpu_wr_hi,
  input  logic [BUS_W-1:0] cpu_wdata,
  input  logic             xfer_done,
  output logic [CNT_W-1:0] cnt_o,
  output logic             end_o
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, dec_val, wr_val;
  logic             act_zero, act_one, end_q;

  // Active-field decode depends on layout
  always_comb begin
    if (layout == LAYOUT_BLOCK) begin
      act_zero = (cnt_q[BLK_CNT_W-1:0] == '0);
      act_one  = (cnt_q[BLK_CNT_W-1:0] == BLK_CNT_W'(1));
      dec_val  = {cnt_q[CNT_W-1:BLK_CNT_W], cnt_q[BLK_CNT_W-1:0] - BLK_CNT_W'(1)};
    end else begin
      act_zero = (cnt_q == '0);
      act_one  = (cnt_q == CNT_W'(1));
      dec_val  = cnt_q - CNT_W'(1);
    end
  end

  // Half-word write merge; only the implemented upper bits are taken
  always_comb begin
    if (cpu_wr_hi) wr_val = {cpu_wdata[HI_W-1:0], cnt_q[BUS_W-1:0]};
    else           wr_val = {cnt_q[CNT_W-1:BUS_W], cpu_wdata};
  end

  // CPU write outranks the transfer update
  always_comb begin
    if (cpu_wr)                      cnt_d = wr_val;
    else if (xfer_done && !act_zero) cnt_d = dec_val;
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      end_q <= xfer_done && act_one;
    end
  end

  assign cnt_o = cnt_q;
  assign end_o = end_q;

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cpu_wr && act_zero) |=> ($stable(cnt_q) && !end_q));
  // R3
  blk_size_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAYOUT_BLOCK && !cpu_wr) |=> $stable(cnt_q[CNT_W-1:BLK_CNT_W]));
  // R5
  end_on_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && act_one) |=> end_q);
  // R8
  no_end_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !xfer_done) |=> !end_q);
  // R10
  lo_kept_on_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wr_hi) |=> $stable(cnt_q[BUS_W-1:0]));
  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_wr_hi) |=> (cnt_q[BUS_W-1:0] == $past(cpu_wdata)));
endmodule

// File: rtl/dtc_read_snap.sv
module dtc_read_snap #(
  parameter int REG_W = dtc_pkg::REG_W_DEF,
  parameter int BUS_W = dtc_pkg::BUS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] live,
  input  logic             cpu_rd,
  input  logic             cpu_rd_hi,
  input  logic             cpu_rd_long,
  output logic [BUS_W-1:0] cpu_rdata
);
  logic [BUS_W-1:0] snap_q;
  logic             take;

  assign take = cpu_rd && cpu_rd_long && cpu_rd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)    snap_q <= '0;
    else if (take) snap_q <= live[BUS_W-1:0];
  end

  always_comb begin
    if (!cpu_rd)                  cpu_rdata = '0;
    else if (cpu_rd_hi)           cpu_rdata = live[REG_W-1:BUS_W];
    else if (cpu_rd_long)         cpu_rdata = snap_q;
    else                          cpu_rdata = live[BUS_W-1:0];
  end

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(snap_q));
  // R11
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (snap_q == $past(live[BUS_W-1:0])));
endmodule

// File: rtl/dma_tcount_unit.sv
module dma_tcount_unit
  import dtc_pkg::*;
#(
  parameter int REG_W     = REG_W_DEF,
  parameter int BUS_W     = BUS_W_DEF,
  parameter int CNT_W     = CNT_W_DEF,
  parameter int BLK_CNT_W = BLK_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_blk,
  input  logic             cpu_wr,
  input  logic             cpu_wr_hi,
  input  logic [BUS_W-1:0] cpu_wdata,
  input  logic             cpu_rd,
  input  logic             cpu_rd_hi,
  input  logic             cpu_rd_long,
  output logic [BUS_W-1:0] cpu_rdata,
  input  logic             xfer_done,
  output logic [REG_W-1:0] count_o,
  output logic             xfer_end
);
  localparam int PAD_W = REG_W - CNT_W;

  layout_e          layout;
  logic [CNT_W-1:0] cnt;

  assign layout  = mode_blk ? LAYOUT_BLOCK : LAYOUT_NORMAL;
  assign count_o = {{PAD_W{1'b0}}, cnt};

  dtc_count_core #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .BLK_CNT_W(BLK_CNT_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .layout(layout),
    .cpu_wr(cpu_wr), .cpu_wr_hi(cpu_wr_hi), .cpu_wdata(cpu_wdata),
    .xfer_done(xfer_done), .cnt_o(cnt), .end_o(xfer_end)
  );

  dtc_read_snap #(
    .REG_W(REG_W), .BUS_W(BUS_W)
  ) u_snap (
    .clk(clk), .rst_n(rst_n), .live(count_o),
    .cpu_rd(cpu_rd), .cpu_rd_hi(cpu_rd_hi), .cpu_rd_long(cpu_rd_long),
    .cpu_rdata(cpu_rdata)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (count_o == '0 && !xfer_end));
endmodule

// File: tb/dma_tcount_unit_tb.sv
`timescale 1ns/1ps
module dma_tcount_unit_tb;
  logic        clk = 0, rst_n = 0, mode_blk = 0;
  logic        cpu_wr = 0, cpu_wr_hi = 0, cpu_rd = 0, cpu_rd_hi = 0, cpu_rd_long = 0;
  logic [15:0] cpu_wdata = 0;
  logic [15:0] cpu_rdata;
  logic        xfer_done = 0, xfer_end;
  logic [31:0] count_o;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_tcount_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode_blk(mode_blk),
    .cpu_wr(cpu_wr), .cpu_wr_hi(cpu_wr_hi), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rd_hi(cpu_rd_hi), .cpu_rd_long(cpu_rd_long),
    .cpu_rdata(cpu_rdata), .xfer_done(xfer_done),
    .count_o(count_o), .xfer_end(xfer_end)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle: optional write, optional transfer
  task automatic cyc(logic wr, logic hi, logic [15:0] d, logic xd);
    cpu_wr = wr; cpu_wr_hi = hi; cpu_wdata = d; xfer_done = xd;
    tick();
    cpu_wr = 0; xfer_done = 0;
  endtask

  task automatic load(logic [23:0] v);
    cyc(1, 1, {8'h00, v[23:16]}, 0);
    cyc(1, 0, v[15:0], 0);
  endtask

  task automatic rd(logic hi, logic lng, output logic [15:0] d);
    cpu_rd = 1; cpu_rd_hi = hi; cpu_rd_long = lng;
    #1 d = cpu_rdata;
    tick();
    cpu_rd = 0; cpu_rd_long = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 count", count_o, 0);
    chk("R1 end", {31'b0, xfer_end}, 0);
    rd(0, 1, d);
    chk("R1 snapshot", {16'b0, d}, 0);
  endtask

  task automatic t_normal();
    mode_blk = 0;
    load(24'h010000);
    cyc(0, 0, 0, 1);
    chk("R2 borrow", count_o, 32'h00FFFF);
    load(24'h000001);
    cyc(0, 0, 0, 1);
    chk("R5 count", count_o, 0);
    chk("R5 pulse", {31'b0, xfer_end}, 1);
    tick();
    chk("R5 single", {31'b0, xfer_end}, 0);
    cyc(0, 0, 0, 1);
    chk("R4 hold", count_o, 0);
    chk("R4 no end", {31'b0, xfer_end}, 0);
  endtask

  task automatic t_block();
    logic [15:0] d;
    mode_blk = 1;
    cyc(1, 1, 16'hAB5A, 0);
    chk("R9 upper", count_o, 32'h5A0000);
    rd(1, 0, d);
    chk("R9 read hi", {16'b0, d}, 32'h005A);
    cyc(1, 0, 16'h0002, 0);
    chk("R10 lo write", count_o, 32'h5A0002);
    cyc(0, 0, 0, 1);
    chk("R3 dec", count_o, 32'h5A0001);
    cyc(0, 0, 0, 1);
    chk("R3 keep size", count_o, 32'h5A0000);
    chk("R5 block end", {31'b0, xfer_end}, 1);
    cyc(0, 0, 0, 1);
    chk("R4 block hold", count_o, 32'h5A0000);
    chk("R4 block no end", {31'b0, xfer_end}, 0);
    mode_blk = 0;
  endtask

  task automatic t_contention();
    load(24'h000005);
    cyc(1, 0, 16'h0100, 1);
    chk("R6 lo write", count_o, 32'h000100);
    load(24'h010001);
    cyc(1, 1, 16'h0002, 1);
    chk("R6 hi write", count_o, 32'h020001);
    chk("R6 no end", {31'b0, xfer_end}, 0);
    load(24'h000001);
    cyc(1, 0, 16'h0042, 1);
    chk("R7 value", count_o, 32'h000042);
    chk("R7 end", {31'b0, xfer_end}, 1);
    load(24'h000003);
    cyc(1, 0, 16'h0000, 0);
    chk("R8 value", count_o, 0);
    chk("R8 no end", {31'b0, xfer_end}, 0);
  endtask

  task automatic t_snapshot();
    logic [15:0] d;
    load(24'h120000);
    rd(1, 1, d);
    chk("R11 long hi", {16'b0, d}, 32'h0012);
    cyc(0, 0, 0, 1);
    chk("R11 live", count_o, 32'h11FFFF);
    rd(0, 1, d);
    chk("R11 long lo", {16'b0, d}, 32'h0000);
    rd(0, 0, d);
    chk("R11 plain lo", {16'b0, d}, 32'hFFFF);
    rd(1, 0, d);
    chk("R11 plain hi", {16'b0, d}, 32'h0011);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_normal();
    t_block();
    t_contention();
    t_snapshot();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule